// File: doc/BRIEF.md
# Multichannel Sample Aligner with Zero Fill

This block takes a stream of audio samples, each tagged with the channel it belongs to, and turns it into complete sample sets in fixed channel order. The number of active channels is 2, 4, 6 or 8 and comes from a two-bit setting. Within one set the channels may arrive in any order. If a channel shows up a second time before every channel of the set has been seen, some samples have gone missing. The block then closes the open set with zeros in the empty slots, and the repeated sample opens the next set.

Completed sets are collected in a buffer that holds `DEPTH` sets per channel, eight by default. When the buffer is full, the whole buffer is sent out as one contiguous burst, set by set, with channel 0 first in each set. The first and last words of the burst are marked. While a burst is being read out, the input is held off with a ready signal, so no sample is lost. Samples whose channel number is outside the active range are accepted and thrown away.

Top module: `chan_set_aligner`

## Requirements
- R1: Samples of one set are accepted in any channel order, and each is stored in the slot of its own channel.
- R2: Inside a burst, every set is output with channel 0 first and channel N-1 last. Sets come out in the order in which they were opened.
- R3: A sample for a channel that already holds data in the open set closes that set. Every empty slot of the closed set is output as zero, and the repeated sample becomes the first entry of the following set.
- R4: A burst is DEPTH*N consecutive output words. `out_first` is high only on the first word and `out_last` only on the last, and both are high only together with `out_valid`.
- R5: A burst starts once the set in position DEPTH-1 is complete.
- R6: Suppose a channel repeats while the set in position DEPTH-1 is still open. That set is zero-filled and flushed at once, and the repeated sample is kept as the first entry of set 0 of the next buffer.
- R7: `cfg_chan_sel` selects N = 2, 4, 6 or 8 active channels for the codes 0, 1, 2 and 3.
- R8: A sample whose `in_chan` is N or higher is accepted and dropped. It changes no output word and fills no slot.
- R9: `in_ready` goes low in the cycle after the sample that triggers a burst. It stays low for exactly DEPTH*N cycles.
- R10: After reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_chan_sel | input | 2 | Active channel count code (0:2, 1:4, 2:6, 3:8). Held constant while samples are buffered |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Input sample can be taken |
| in_chan | input | 3 | Channel number of the input sample |
| in_data | input | DATA_W | Input sample value |
| out_valid | output | 1 | Output word present |
| out_first | output | 1 | First word of a burst |
| out_last | output | 1 | Last word of a burst |
| out_chan | output | 3 | Channel of the output word |
| out_data | output | DATA_W | Output sample, zero for a missing sample |

## Verification
The bench builds the block with DATA_W of 16 and the default DEPTH of 8. A buffer therefore fills within a few dozen input samples for every channel count, and all four channel codes fit in a short run. At this depth both flush causes can be reached: a complete eighth set, and a repeat while the eighth set is still open. The early case also shows whether the held-back sample lands in the next buffer. The smallest burst is 16 words, which keeps the count of ready-low cycles easy to check.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int CSA_MAX_CH = 8;
  localparam int CSA_CH_W   = $clog2(CSA_MAX_CH);
  localparam int CSA_CNT_W  = CSA_CH_W + 1;

  // code 0..3 -> 2, 4, 6, 8 active channels
  function automatic logic [CSA_CNT_W-1:0] chan_count(input logic [1:0] sel);
    return {1'b0, sel, 1'b0} + 4'd2;
  endfunction
endpackage

// File: rtl/sa_sample_ram.sv
module sa_sample_ram #(
  parameter int DATA_W = 24,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 2 ** AW;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sa_fill_track.sv
module sa_fill_track #(
  parameter int DEPTH  = 8,
  parameter int MAX_CH = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [$clog2(MAX_CH):0]   nch,
  input  logic                      smp_fire,
  input  logic [$clog2(MAX_CH)-1:0] smp_ch,
  input  logic                      flush_done,
  input  logic                      pend_v,
  input  logic [$clog2(MAX_CH)-1:0] pend_ch,
  input  logic [$clog2(DEPTH)-1:0]  rd_set,
  input  logic [$clog2(MAX_CH)-1:0] rd_ch,
  output logic                      wr_en,
  output logic [$clog2(DEPTH)-1:0]  wr_set,
  output logic [$clog2(MAX_CH)-1:0] wr_ch,
  output logic                      wr_pend,
  output logic                      flush_start,
  output logic                      stash,
  output logic                      rd_keep
);
  localparam int SET_W = $clog2(DEPTH);
  localparam int CH_W  = $clog2(MAX_CH);

  logic [MAX_CH-1:0] mask [DEPTH];
  logic [SET_W-1:0]  cur_set;
  logic [SET_W-1:0]  nxt_set;
  logic [MAX_CH-1:0] full_pat;
  logic [MAX_CH-1:0] ch_bit;
  logic              dup, fills, last_set;

  always_comb begin
    for (int i = 0; i < MAX_CH; i++) full_pat[i] = ((CH_W+1)'(i) < nch);
  end

  assign ch_bit   = MAX_CH'(1) << smp_ch;
  assign nxt_set  = cur_set + 1'b1;
  assign dup      = mask[cur_set][smp_ch];
  assign last_set = (cur_set == SET_W'(DEPTH - 1));
  assign fills    = (((mask[cur_set] | ch_bit) & full_pat) == full_pat);
  assign rd_keep  = mask[rd_set][rd_ch];

  always_comb begin
    wr_en       = 1'b0;
    wr_set      = cur_set;
    wr_ch       = smp_ch;
    wr_pend     = 1'b0;
    flush_start = 1'b0;
    stash       = 1'b0;
    if (flush_done) begin
      wr_en   = pend_v;
      wr_set  = '0;
      wr_ch   = pend_ch;
      wr_pend = 1'b1;
    end else if (smp_fire) begin
      if (!dup) begin
        wr_en       = 1'b1;
        flush_start = fills && last_set;
      end else if (last_set) begin
        flush_start = 1'b1;
        stash       = 1'b1;
      end else begin
        wr_en  = 1'b1;
        wr_set = nxt_set;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < DEPTH; s++) mask[s] <= '0;
      cur_set <= '0;
    end else if (flush_done) begin
      for (int s = 0; s < DEPTH; s++) mask[s] <= '0;
      if (pend_v) mask[0][pend_ch] <= 1'b1;
      cur_set <= '0;
    end else if (smp_fire) begin
      if (!dup) begin
        mask[cur_set][smp_ch] <= 1'b1;
        if (fills && !last_set) cur_set <= nxt_set;
      end else if (!last_set) begin
        mask[nxt_set][smp_ch] <= 1'b1;
        cur_set <= nxt_set;
      end
    end
  end
endmodule

// File: rtl/sa_flush_seq.sv
module sa_flush_seq #(
  parameter int DEPTH  = 8,
  parameter int MAX_CH = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [$clog2(MAX_CH):0]   nch,
  output logic                      busy,
  output logic [$clog2(DEPTH)-1:0]  rd_set,
  output logic [$clog2(MAX_CH)-1:0] rd_ch,
  output logic                      rd_first,
  output logic                      rd_last
);
  localparam int SET_W = $clog2(DEPTH);

  logic ch_end, set_end;

  assign ch_end   = ({1'b0, rd_ch} == nch - 1'b1);
  assign set_end  = (rd_set == SET_W'(DEPTH - 1));
  assign rd_first = busy && (rd_set == '0) && (rd_ch == '0);
  assign rd_last  = busy && ch_end && set_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      rd_set <= '0;
      rd_ch  <= '0;
    end else if (!busy) begin
      busy   <= start;
      rd_set <= '0;
      rd_ch  <= '0;
    end else if (ch_end) begin
      rd_ch <= '0;
      if (set_end) busy <= 1'b0;
      else         rd_set <= rd_set + 1'b1;
    end else begin
      rd_ch <= rd_ch + 1'b1;
    end
  end
endmodule

// File: rtl/chan_set_aligner.sv
module chan_set_aligner
  import csa_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int DEPTH  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          cfg_chan_sel,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [CSA_CH_W-1:0] in_chan,
  input  logic [DATA_W-1:0]   in_data,
  output logic                out_valid,
  output logic                out_first,
  output logic                out_last,
  output logic [CSA_CH_W-1:0] out_chan,
  output logic [DATA_W-1:0]   out_data
);
  localparam int MAX_CH = CSA_MAX_CH;
  localparam int CH_W   = CSA_CH_W;
  localparam int SET_W  = $clog2(DEPTH);
  localparam int AW     = SET_W + CH_W;

  logic [CH_W:0]       nch;
  logic                busy, accept, in_use;
  logic [SET_W-1:0]    rd_set, wr_set;
  logic [CH_W-1:0]     rd_ch, wr_ch;
  logic                rd_first, rd_last, rd_keep;
  logic                wr_en, wr_pend, flush_start, stash;
  logic                pend_v;
  logic [CH_W-1:0]     pend_ch;
  logic [DATA_W-1:0]   pend_data;
  logic [DATA_W-1:0]   ram_q;
  logic                s1_v, s1_keep, s1_first, s1_last;
  logic [CH_W-1:0]     s1_ch;

  assign nch      = chan_count(cfg_chan_sel);
  assign in_ready = ~busy;
  assign accept   = in_valid & ~busy;
  assign in_use   = accept && ({1'b0, in_chan} < nch);

  sa_fill_track #(.DEPTH(DEPTH), .MAX_CH(MAX_CH)) u_track (
    .clk(clk), .rst(rst), .nch(nch),
    .smp_fire(in_use), .smp_ch(in_chan),
    .flush_done(rd_last), .pend_v(pend_v), .pend_ch(pend_ch),
    .rd_set(rd_set), .rd_ch(rd_ch),
    .wr_en(wr_en), .wr_set(wr_set), .wr_ch(wr_ch), .wr_pend(wr_pend),
    .flush_start(flush_start), .stash(stash), .rd_keep(rd_keep)
  );

  sa_flush_seq #(.DEPTH(DEPTH), .MAX_CH(MAX_CH)) u_seq (
    .clk(clk), .rst(rst), .start(flush_start), .nch(nch),
    .busy(busy), .rd_set(rd_set), .rd_ch(rd_ch),
    .rd_first(rd_first), .rd_last(rd_last)
  );

  sa_sample_ram #(.DATA_W(DATA_W), .AW(AW)) u_ram (
    .clk(clk), .we(wr_en), .waddr({wr_set, wr_ch}),
    .wdata(wr_pend ? pend_data : in_data),
    .raddr({rd_set, rd_ch}), .rdata(ram_q)
  );

  // sample that overflowed the last open set waits here for the next buffer
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v    <= 1'b0;
      pend_ch   <= '0;
      pend_data <= '0;
    end else if (stash) begin
      pend_v    <= 1'b1;
      pend_ch   <= in_chan;
      pend_data <= in_data;
    end else if (rd_last) begin
      pend_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v     <= 1'b0;
      s1_keep  <= 1'b0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
      s1_ch    <= '0;
    end else begin
      s1_v     <= busy;
      s1_keep  <= rd_keep;
      s1_first <= rd_first;
      s1_last  <= rd_last;
      s1_ch    <= rd_ch;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_last  <= 1'b0;
      out_chan  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_v;
      out_first <= s1_v & s1_first;
      out_last  <= s1_v & s1_last;
      out_chan  <= s1_v ? s1_ch : '0;
      out_data  <= (s1_v && s1_keep) ? ram_q : '0;
    end
  end
endmodule

// File: rtl/chan_set_aligner_chk.sv
module chan_set_aligner_chk
  import csa_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          cfg_chan_sel,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_first,
  input logic                out_last,
  input logic [CSA_CH_W-1:0] out_chan
);
  logic [CSA_CNT_W-1:0] nch;
  logic [15:0]          bcnt;

  assign nch = chan_count(cfg_chan_sel);

  always_ff @(posedge clk) begin
    if (rst)            bcnt <= '0;
    else if (out_valid) bcnt <= out_last ? 16'd0 : bcnt + 16'd1;
  end

  AST_FIRST_IS_CH0: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_first |-> out_chan == '0); // R2
  AST_LAST_IS_TOP: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last |-> {1'b0, out_chan} == nch - 1'b1); // R2
  AST_CHAN_STEP: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_last |=> out_valid &&
      ({1'b0, out_chan} == ((({1'b0, $past(out_chan)} + 4'd1) == nch) ? 4'd0
                            : {1'b0, $past(out_chan)} + 4'd1))); // R2
  AST_BURST_LEN: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last |-> 32'(bcnt) == DEPTH * 32'(nch) - 1); // R4
  AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (rst)
    (out_first || out_last) |-> out_valid); // R4
  AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> {1'b0, out_chan} < nch); // R8
  AST_READY_LOW_IN_BURST: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_first |-> !in_ready); // R9
endmodule

bind chan_set_aligner chan_set_aligner_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cfg_chan_sel(cfg_chan_sel), .in_ready(in_ready),
  .out_valid(out_valid), .out_first(out_first), .out_last(out_last),
  .out_chan(out_chan)
);

// File: tb/chan_set_aligner_bench.sv
module chan_set_aligner_bench;
  localparam int DW    = 16;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    cfg_chan_sel = 2'd0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2:0]    in_chan = 3'd0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid, out_first, out_last;
  logic [2:0]    out_chan;
  logic [DW-1:0] out_data;

  int n_chk  = 0;
  int n_fail = 0;

  // reference store, written from the requirements
  logic [DW-1:0] mdat  [DEPTH][8];
  bit            mmask [DEPTH][8];
  int            mset, mn;
  logic [DW-1:0] e_data [1024];
  int            e_ch   [1024];
  bit            e_f [1024], e_l [1024];
  int            e_n;
  logic [DW-1:0] r_data [1024];
  int            r_ch   [1024];
  bit            r_f [1024], r_l [1024];
  int            r_n;

  chan_set_aligner #(.DATA_W(DW), .DEPTH(DEPTH)) u_chan_set_aligner (
    .clk(clk), .rst(rst), .cfg_chan_sel(cfg_chan_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan), .in_data(in_data),
    .out_valid(out_valid), .out_first(out_first), .out_last(out_last),
    .out_chan(out_chan), .out_data(out_data)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (!rst && out_valid && r_n < 1024) begin
      r_data[r_n] = out_data;
      r_ch[r_n]   = int'(out_chan);
      r_f[r_n]    = out_first;
      r_l[r_n]    = out_last;
      r_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_flush();
    for (int s = 0; s < DEPTH; s++)
      for (int c = 0; c < mn; c++) begin
        e_data[e_n] = mmask[s][c] ? mdat[s][c] : '0;
        e_ch[e_n]   = c;
        e_f[e_n]    = (s == 0 && c == 0);
        e_l[e_n]    = (s == DEPTH-1 && c == mn-1);
        e_n++;
      end
    for (int s = 0; s < DEPTH; s++)
      for (int c = 0; c < 8; c++) mmask[s][c] = 0;
    mset = 0;
  endtask

  task automatic model_put(input int c, input logic [DW-1:0] d);
    bit full;
    if (c >= mn) return;
    if (mmask[mset][c]) begin
      if (mset == DEPTH-1) model_flush();
      else mset++;
    end
    mdat[mset][c]  = d;
    mmask[mset][c] = 1;
    full = 1;
    for (int k = 0; k < mn; k++) if (!mmask[mset][k]) full = 0;
    if (full) begin
      if (mset == DEPTH-1) model_flush();
      else mset++;
    end
  endtask

  task automatic send(input int c, input logic [DW-1:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_chan  = 3'(c);
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
    model_put(c, d);
  endtask

  task automatic restart(input logic [1:0] sel);
    @(negedge clk);
    rst = 1'b1;
    cfg_chan_sel = sel;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mn = 2 * int'(sel) + 2;
    mset = 0;
    for (int s = 0; s < DEPTH; s++)
      for (int c = 0; c < 8; c++) mmask[s][c] = 0;
    e_n = 0;
    r_n = 0;
  endtask

  task automatic compare(input string req);
    repeat (DEPTH * 8 + 10) @(negedge clk);
    chk(r_n == e_n, req, "word count", r_n, e_n);
    for (int i = 0; i < e_n && i < r_n; i++)
      chk(r_data[i] == e_data[i] && r_ch[i] == e_ch[i] && r_f[i] == e_f[i] && r_l[i] == e_l[i],
          req, $sformatf("word %0d {data,chan,first,last}", i),
          {32'(r_data[i]), 8'(r_ch[i]), 4'(r_f[i]), 4'(r_l[i])},
          {32'(e_data[i]), 8'(e_ch[i]), 4'(e_f[i]), 4'(e_l[i])});
  endtask

  task automatic t_reset();
    restart(2'd0);
    chk(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
  endtask

  // R1 R2 R5: reversed arrival per set, burst after eighth set
  task automatic t_order();
    restart(2'd0);
    for (int s = 0; s < DEPTH; s++) begin
      send(1, DW'(16'h1000 + s * 16 + 1));
      send(0, DW'(16'h1000 + s * 16));
    end
    compare("R1 R2");
    chk(r_n == 2 * DEPTH, "R5", "burst after full eighth set", r_n, 2 * DEPTH);
  endtask

  // R3: order 0,1,1,0,0,0,1 gives sets {a,b},{a,b},{a,0},{a,b}
  task automatic t_missing();
    int seq [7] = '{0, 1, 1, 0, 0, 0, 1};
    restart(2'd0);
    foreach (seq[i]) send(seq[i], DW'(16'h2000 + i));
    for (int s = 0; s < 4; s++) begin
      send(0, DW'(16'h2100 + s));
      send(1, DW'(16'h2200 + s));
    end
    compare("R3");
    chk(r_data[3] == 16'h2002, "R3", "set1 ch1 reordered", r_data[3], 16'h2002);
    chk(r_data[5] == '0, "R3", "set2 ch1 zero filled", r_data[5], 0);
    chk(r_data[6] == 16'h2005, "R3", "repeat opens set3", r_data[6], 16'h2005);
  endtask

  // R7: channel counts 6 and 8 with scrambled arrival
  task automatic t_cfg(input logic [1:0] sel);
    int n;
    restart(sel);
    n = 2 * int'(sel) + 2;
    for (int s = 0; s < DEPTH; s++)
      for (int k = 0; k < n; k++) begin
        int c;
        c = (sel == 2'd3) ? ((3 * k + s) % 8) : (n - 1 - k);
        send(c, DW'(16'h3000 + 16'(sel) * 16'h100 + s * 16 + c));
      end
    compare("R7 R1");
    chk(r_n == DEPTH * n, "R7", "burst length for code", r_n, DEPTH * n);
  endtask

  // R8: channels at or above the active count are dropped
  task automatic t_drop();
    restart(2'd1);
    for (int s = 0; s < DEPTH; s++) begin
      send(5, 16'hDEAD);
      for (int c = 0; c < 4; c++) begin
        send(c, DW'(16'h4000 + s * 16 + c));
        if (c == 1) send(4 + (s % 4), 16'hBEEF);
      end
    end
    compare("R8");
  endtask

  // R6 R9: repeat while the last set is open
  task automatic t_early();
    int lowc;
    restart(2'd0);
    for (int s = 0; s < DEPTH-1; s++) begin
      send(0, DW'(16'h5000 + s * 16));
      send(1, DW'(16'h5001 + s * 16));
    end
    send(1, 16'h5071);
    send(1, 16'h5AAA);
    lowc = 0;
    while (!in_ready && lowc < 1000) begin
      lowc++;
      @(negedge clk);
    end
    chk(lowc == 2 * DEPTH, "R9", "ready-low cycles", lowc, 2 * DEPTH);
    send(0, 16'h5BBB);
    for (int s = 1; s < DEPTH; s++) begin
      send(1, DW'(16'h6001 + s * 16));
      send(0, DW'(16'h6000 + s * 16));
    end
    compare("R6");
    chk(r_data[14] == '0, "R6", "last set ch0 zero", r_data[14], 0);
    chk(r_data[17] == 16'h5AAA, "R6", "held sample in next buffer", r_data[17], 16'h5AAA);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_order();
    t_missing();
    t_cfg(2'd2);
    t_cfg(2'd3);
    t_drop();
    t_early();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule